// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a parallel flash device and decides when an embedded program or erase operation has finished. After a one-cycle `start`, it reads the device status byte repeatedly through a single-outstanding read handshake. When it has an answer it raises `done` for one cycle, with `pass` and `timed_out` giving the outcome. It does not issue the flash command sequence itself; it only watches for completion.

Two detection methods are selectable per operation. In data-compare mode, the poll bit (bit 7) is compared against the value the operation should leave behind. That value is the programmed bit for a program and 1 for an erase. In toggle mode, the toggle bit (bit 6) is compared between successive reads, and a stable value means the device has stopped working. In both modes the error flag (bit 5) never produces a fail by itself. The controller always takes confirming reads first, because the operation may have finished on the very read that showed the flag. A parameterised read limit can end a poll that never resolves, and that case is reported as a fail.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset the controller is idle: `rd_req`, `busy` and `done` are 0.
- R2: A `start` pulse while idle begins polling. `rd_req` is held at 1 until a cycle with `rd_valid`=1, and only one read is outstanding at a time. `rd_valid` is ignored while no read is requested.
- R3: In data-compare mode (`toggle_mode`=0), a read whose bit 7 equals the expected bit ends the poll with `pass`=1.
- R4: In data-compare mode, a read whose bit 7 differs from the expected bit and whose bit 5 is 0 causes another read.
- R5: In data-compare mode, a read whose bit 7 differs and whose bit 5 is 1 causes exactly one more read. Bit 7 of that read decides the result: equal gives pass, different gives fail.
- R6: In toggle mode (`toggle_mode`=1), the first read only records bit 6. A later read whose bit 6 equals the previous read's bit 6 ends the poll with `pass`=1.
- R7: In toggle mode, a read whose bit 6 differs from the previous read and whose bit 5 is 0 causes another read, compared against this read's bit 6.
- R8: In toggle mode, a read whose bit 6 differs from the previous read and whose bit 5 is 1 causes two more reads. Equal bit 6 on those two reads gives pass; different gives fail.
- R9: With `erase_op`=1 the expected bit is 1 whatever `prog_bit` is. With `erase_op`=0 it is `prog_bit`. Both are captured at `start`.
- R10: When MAX_POLLS is non-zero and the MAX_POLLS-th read of a poll does not resolve it, the poll ends with `pass`=0 and `timed_out`=1. A read that resolves the poll on that same read gives its normal result with `timed_out`=0.
- R11: `done` is a one-cycle pulse, one cycle after the deciding read is accepted. `pass` and `timed_out` hold until the next start, and `start` while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a poll (sampled while idle) |
| toggle_mode | input | 1 | 0 = data-compare, 1 = toggle detection |
| erase_op | input | 1 | Operation being watched is an erase |
| prog_bit | input | 1 | Bit 7 of the programmed data (program only) |
| rd_req | output | 1 | Status read requested |
| rd_valid | input | 1 | Status read data valid |
| rd_data | input | DW | Status byte returned by the read |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result: operation succeeded |
| timed_out | output | 1 | Result: read limit reached |

## Verification
The hardest situation to create is the error flag appearing on the read where the device finishes. The poll must then resolve through the confirming reads, and sometimes this happens on exactly the last read the limit allows. The stimulus feeds scripted and biased-random status byte sequences. Bit 5 is set on about a quarter of the reads, and the bench limit is set low, so that these orderings occur often. Each sequence is scored by a bench model of the algorithm. Random response latency and stray `start` pulses during waits exercise the handshake and the rule that starts are ignored while busy.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
   typedef enum logic [2:0] {
      PH_DP_FIRST,
      PH_DP_RECHECK,
      PH_TG_REF,
      PH_TG_CMP,
      PH_TG_RE1,
      PH_TG_RE2
   } phase_t;

   typedef enum logic [1:0] {
      DEC_MORE,
      DEC_PASS,
      DEC_FAIL
   } dec_t;

   typedef enum logic {
      ST_IDLE,
      ST_READ
   } state_t;
endpackage

// File: rtl/poll_eval.sv
module poll_eval
   import flash_poll_pkg::*;
#(
   parameter int DW       = 8,
   parameter int POLL_BIT = 7,
   parameter int TOG_BIT  = 6,
   parameter int ERR_BIT  = 5
) (
   input  phase_t          phase,
   input  logic [DW-1:0]   sample,
   input  logic            prev_tog,
   input  logic            exp_bit,
   output dec_t            dec,
   output phase_t          nxt_phase
);
   generate
      if (POLL_BIT >= DW || TOG_BIT >= DW || ERR_BIT >= DW) begin : g_bad_bits
         $error("poll_eval: status bit index outside data width");
      end
   endgenerate

   logic poll_ok, tog_same, err_seen;
   assign poll_ok  = (sample[POLL_BIT] == exp_bit);
   assign tog_same = (sample[TOG_BIT] == prev_tog);
   assign err_seen = sample[ERR_BIT];

   logic unused_bits;
   assign unused_bits = ^sample;

   always_comb begin
      dec       = DEC_MORE;
      nxt_phase = phase;
      case (phase)
         PH_DP_FIRST: begin
            if (poll_ok)       dec = DEC_PASS;
            else if (err_seen) nxt_phase = PH_DP_RECHECK;
         end
         PH_DP_RECHECK: dec = poll_ok ? DEC_PASS : DEC_FAIL;
         PH_TG_REF:     nxt_phase = PH_TG_CMP;
         PH_TG_CMP: begin
            if (tog_same)      dec = DEC_PASS;
            else if (err_seen) nxt_phase = PH_TG_RE1;
         end
         PH_TG_RE1:     nxt_phase = PH_TG_RE2;
         PH_TG_RE2:     dec = tog_same ? DEC_PASS : DEC_FAIL;
         default:       dec = DEC_FAIL;
      endcase
   end
endmodule

// File: rtl/poll_limit.sv
module poll_limit #(
   parameter int MAX_POLLS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last
);
   localparam int LIM = (MAX_POLLS == 0) ? 1 : MAX_POLLS;
   localparam int CW  = $clog2(LIM + 1);

   generate
      if (MAX_POLLS < 0) begin : g_bad_lim
         $error("poll_limit: MAX_POLLS must not be negative");
      end
      if (MAX_POLLS == 0) begin : g_no_limit
         logic unused_in;
         assign unused_in = ^{clk, rst_n, clear, step};
         assign last = 1'b0;
      end else begin : g_limit
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt <= '0;
            else if (clear) cnt <= '0;
            else if (step)  cnt <= cnt + 1'b1;
         end
         assign last = step && (cnt == CW'(LIM - 1));

         assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CW'(LIM));
      end
   endgenerate
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
   import flash_poll_pkg::*;
#(
   parameter int DW        = 8,
   parameter int POLL_BIT  = 7,
   parameter int TOG_BIT   = 6,
   parameter int ERR_BIT   = 5,
   parameter int MAX_POLLS = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          toggle_mode,
   input  logic          erase_op,
   input  logic          prog_bit,
   output logic          rd_req,
   input  logic          rd_valid,
   input  logic [DW-1:0] rd_data,
   output logic          busy,
   output logic          done,
   output logic          pass,
   output logic          timed_out
);
   state_t state;
   phase_t phase, nxt_phase;
   dec_t   dec;
   logic   prev_tog, exp_q, done_q, pass_q, to_q, last_read;
   logic   accept, launch;

   assign accept = (state == ST_READ) && rd_valid;
   assign launch = (state == ST_IDLE) && start;

   poll_eval #(
      .DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT), .ERR_BIT(ERR_BIT)
   ) u_eval (
      .phase(phase), .sample(rd_data), .prev_tog(prev_tog), .exp_bit(exp_q),
      .dec(dec), .nxt_phase(nxt_phase)
   );

   poll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
      .clk(clk), .rst_n(rst_n), .clear(launch), .step(accept), .last(last_read)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         phase    <= PH_DP_FIRST;
         prev_tog <= 1'b0;
         exp_q    <= 1'b0;
         done_q   <= 1'b0;
         pass_q   <= 1'b0;
         to_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               state  <= ST_READ;
               phase  <= toggle_mode ? PH_TG_REF : PH_DP_FIRST;
               exp_q  <= erase_op | prog_bit;
               pass_q <= 1'b0;
               to_q   <= 1'b0;
            end
            ST_READ: if (rd_valid) begin
               prev_tog <= rd_data[TOG_BIT];
               if (dec == DEC_PASS) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
                  pass_q <= 1'b1;
               end else if (dec == DEC_FAIL) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end else if (last_read) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
                  to_q   <= 1'b1;
               end else begin
                  phase <= nxt_phase;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign rd_req    = (state == ST_READ);
   assign busy      = (state == ST_READ);
   assign done      = done_q;
   assign pass      = pass_q;
   assign timed_out = to_q;

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> rd_req);
   assert_timeout_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && timed_out) |-> !pass);
   assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !rd_valid) |=> (busy && $stable(phase)));
endmodule

// File: tb/tb_flash_poll_ctrl.sv
module tb_flash_poll_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int MAXP       = 8;

   logic clk = 0, rst_n = 0;
   logic start = 0, toggle_mode = 0, erase_op = 0, prog_bit = 0, rd_valid = 0;
   logic [7:0] rd_data = 0;
   logic rd_req, busy, done, pass, timed_out;

   int vectors = 0, errors = 0;
   logic [7:0] stat [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_poll_ctrl #(.MAX_POLLS(MAXP)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .toggle_mode(toggle_mode),
      .erase_op(erase_op), .prog_bit(prog_bit), .rd_req(rd_req),
      .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
      .pass(pass), .timed_out(timed_out)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void model(input bit tm, input bit expb,
                                 output bit ps, output bit to, output int used);
      int i = 0;
      bit fin = 0;
      bit prev;
      logic [7:0] b;
      ps = 0; to = 0;
      if (!tm) begin
         while (!fin) begin
            b = stat[i]; i++;
            if (b[7] == expb) begin ps = 1; fin = 1; end
            else if (i == MAXP) begin to = 1; fin = 1; end
            else if (b[5]) begin
               b = stat[i]; i++; ps = (b[7] == expb); fin = 1;
            end
         end
      end else begin
         b = stat[i]; i++; prev = b[6];
         if (i == MAXP) begin to = 1; fin = 1; end
         while (!fin) begin
            b = stat[i]; i++;
            if (b[6] == prev) begin ps = 1; fin = 1; end
            else if (i == MAXP) begin to = 1; fin = 1; end
            else if (!b[5]) prev = b[6];
            else begin
               b = stat[i]; i++; prev = b[6];
               if (i == MAXP) begin to = 1; fin = 1; end
               else begin b = stat[i]; i++; ps = (b[6] == prev); fin = 1; end
            end
         end
      end
      used = i;
   endfunction

   task automatic run_op(input bit tm, input bit er, input bit pb, input string req);
      bit e_ps, e_to, got;
      int e_used, idx, wl;
      model(tm, er | pb, e_ps, e_to, e_used);
      @(negedge clk);
      toggle_mode = tm; erase_op = er; prog_bit = pb; start = 1;
      @(negedge clk);
      start = 0; idx = 0; got = 0; wl = $urandom_range(0, 2);
      for (int cyc = 0; cyc < 300 && !got; cyc++) begin
         start = 0; rd_valid = 0;
         if (done) got = 1;
         else begin
            if (rd_req && wl == 0 && idx < 64) begin
               rd_data = stat[idx]; idx++; rd_valid = 1; wl = $urandom_range(0, 2);
            end else begin
               if (wl > 0) wl--;
               if ($urandom_range(0, 3) == 0) start = 1;   // R11 start while busy
            end
            @(negedge clk);
         end
      end
      check(got, 1, {req, " done seen"});
      check(pass, e_ps, {req, " pass"});
      check(timed_out, e_to, {req, " R10 timed_out"});
      check(idx, e_used, {req, " R2 read count"});
      @(negedge clk);
      check(done, 0, "R11 done pulse width");
      check(pass, e_ps, "R11 pass held");
   endtask

   task automatic load(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
      for (int k = 0; k < 64; k++) stat[k] = 8'h00;
      stat[0] = b0; stat[1] = b1; stat[2] = b2; stat[3] = b3;
      stat[4] = b4; stat[5] = b5; stat[6] = b6; stat[7] = b7;
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin @(posedge clk); cyc++; end
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check(rd_req, 0, "R1 rd_req at reset");
      check(busy, 0, "R1 busy at reset");
      check(done, 0, "R1 done at reset");
      rst_n = 1;
      @(negedge clk);
      // R2: stray read data while idle
      rd_valid = 1; rd_data = 8'h80;
      @(negedge clk);
      rd_valid = 0;
      @(negedge clk);
      check(rd_req, 0, "R2 idle rd_valid ignored (req)");
      check(done, 0, "R2 idle rd_valid ignored (done)");

      load(8'h80, 0, 0, 0, 0, 0, 0, 0); run_op(0, 1, 0, "R3 R9 erase first read");
      load(8'h00, 8'h00, 8'h80, 0, 0, 0, 0, 0); run_op(0, 0, 1, "R4 program retry");
      load(8'h80, 0, 0, 0, 0, 0, 0, 0); run_op(0, 0, 0, "R9 program expects 0");
      load(8'h20, 8'hA0, 0, 0, 0, 0, 0, 0); run_op(0, 0, 1, "R5 recheck pass");
      load(8'h20, 8'h20, 0, 0, 0, 0, 0, 0); run_op(0, 0, 1, "R5 recheck fail");
      load(8'h40, 8'h40, 0, 0, 0, 0, 0, 0); run_op(1, 0, 0, "R6 toggle stable");
      load(8'h40, 8'h00, 8'h40, 8'h40, 0, 0, 0, 0); run_op(1, 0, 0, "R7 toggle continue");
      load(8'h00, 8'h60, 8'h40, 8'h00, 0, 0, 0, 0); run_op(1, 1, 0, "R8 toggle fail");
      load(8'h00, 8'h60, 8'h40, 8'h40, 0, 0, 0, 0); run_op(1, 1, 0, "R8 toggle pass");
      load(0, 0, 0, 0, 0, 0, 0, 0); run_op(0, 1, 0, "R10 data timeout");
      load(0, 0, 0, 0, 0, 0, 0, 8'h80); run_op(0, 1, 0, "R10 resolve on last");
      load(8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40); run_op(1, 0, 0, "R10 toggle timeout");

      for (int t = 0; t < 60; t++) begin
         for (int k = 0; k < 64; k++) begin
            stat[k] = 8'($urandom);
            stat[k][5] = ($urandom_range(0, 3) == 0);
            stat[k][7] = ($urandom_range(0, 4) == 0);
         end
         run_op(1'($urandom), 1'($urandom), 1'($urandom), "R3 R6 random");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule